// File: doc/BRIEF.md
# Pairwise Sorting Network

This block sorts a group of N unsigned keys, N a power of two, into non-decreasing order with a fixed network of compare-exchange elements. No comparison result at run time changes which positions are compared. The first layer orders each pair of neighbouring positions. The network then sorts the pair minimums and the pair maximums as two independent, interleaved subproblems, one stride doubling after another. A closing merge phase removes the inversions that remain between the two halves. For N = 8 the network uses 19 compare-exchange elements in 6 layers. In general it uses N·lg·(lg−1)/4 + N − 1 elements in lg·(lg+1)/2 layers, where lg = log2(N).

A parent block presents all N keys at once on a flat vector together with a valid strobe. Key i occupies bits [i·W +: W]. The sorted keys appear on a flat vector of the same layout, together with a delayed valid. A parameter selects one of two builds. In one, the network is purely combinational. In the other, a register stage follows every layer, so a new group can enter on every clock cycle.

Top module: `pairsort_net`

## Requirements
- R1: Whenever the output valid is high, the output keys are non-decreasing by index: key i, at bits [i·W +: W], is less than or equal to key i+1, so index 0 holds the smallest key.
- R2: Each valid output group is a permutation of the input group it came from, with every key value kept the same number of times.
- R3: For N = 8, each of the 256 input groups whose keys are all 0 or 1 comes out sorted: all zeros first, then all ones.
- R4: With PIPE = 1, the output valid equals the input valid delayed by lg·(lg+1)/2 cycles (6 for N = 8). The keys of that output belong to the group that was presented with that delayed valid.
- R5: With PIPE = 0, the outputs follow the inputs in the same cycle with no clock involved: the output valid equals the input valid, and the output keys are the sorted input keys.
- R6: A synchronous active-high reset clears every pipeline valid bit. Groups in flight at reset never appear, and the output valid stays low until a group presented after reset has crossed all stages.
- R7: Keys of equal value pass through unchanged. An input group whose keys are all equal appears unchanged at the output.
- R8: Groups presented on consecutive cycles each produce their own sorted output, in the order presented, at one group per cycle.
- R9: An already ascending group comes out unchanged. A strictly descending group comes out reversed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional layer registers |
| rst | input | 1 | Synchronous active-high reset of the valid bits |
| in_vld | input | 1 | Marks the key group on in_keys as present |
| in_keys | input | N*W | N unsigned keys; key i at bits [i*W +: W] |
| out_vld | output | 1 | Marks the sorted group on out_keys as present |
| out_keys | output | N*W | Sorted keys, smallest at index 0 |

## Verification
The full set of 256 zero-one groups is streamed back to back. By the zero-one argument, this set separates a correct network from any network with a missing or misplaced compare-exchange element. It also exercises continuous throughput. Random 8-bit groups with gaps in the valid strobe check that keys are preserved and that valid timing stays aligned with data. Directed groups test specific cases: all-equal keys, ascending order, descending order, and extreme values, which separate swap direction and tie handling from the general case. A reset applied while groups are in flight shows that the stale groups are dropped.

// File: rtl/psort_pkg.sv
package psort_pkg;

    // Number of comparator layers for 2**lg keys.
    function automatic int depth_of(input int lg);
        return lg * (lg + 1) / 2;
    endfunction

    // Partner wire of wire w in layer s, or -1 when w passes straight through.
    // Layers 0..lg-1: pair phase with stride 2**s (w against w ^ stride).
    // Later layers: merge phase, stride a from N/4 down to 1, distance d = 2**k-1 halving to 1.
    function automatic int pair_of(input int lg, input int s, input int w);
        int n;
        int a;
        int d;
        int rem;
        int p;
        n = 1 << lg;
        p = -1;
        a = 0;
        d = 0;
        if (s < lg) begin
            p = w ^ (1 << s);
        end else begin
            rem = s - lg;
            for (int j = 0; j <= lg - 2; j++) begin
                if (a == 0) begin
                    if (rem < j + 1) begin
                        a = n >> (j + 2);
                        d = ((1 << (j + 1)) - 1) >> rem;
                    end else begin
                        rem = rem - (j + 1);
                    end
                end
            end
            if (a != 0) begin
                if ((w & a) != 0) begin
                    if (w + d * a < n) p = w + d * a;
                end else if (w >= (d + 1) * a) begin
                    p = w - d * a;
                end
            end
        end
        return p;
    endfunction

endpackage

// File: rtl/psort_cmp.sv
module psort_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] key_a,
    input  logic [W-1:0] key_b,
    output logic [W-1:0] key_lo,
    output logic [W-1:0] key_hi
);
    logic swap;

    always_comb begin
        swap   = key_b < key_a;
        key_lo = swap ? key_b : key_a;
        key_hi = swap ? key_a : key_b;
    end
endmodule

// File: rtl/psort_layer.sv
module psort_layer #(
    parameter int N   = 8,
    parameter int W   = 8,
    parameter int LG  = 3,
    parameter int SEL = 0
) (
    input  logic [N*W-1:0] keys_in,
    output logic [N*W-1:0] keys_out
);
    for (genvar w = 0; w < N; w++) begin : g_wire
        localparam int P = psort_pkg::pair_of(LG, SEL, w);
        if (P < 0) begin : g_pass
            assign keys_out[w*W +: W] = keys_in[w*W +: W];
        end else if (P > w) begin : g_cmp
            psort_cmp #(.W(W)) u_cmp (
                .key_a  (keys_in[w*W +: W]),
                .key_b  (keys_in[P*W +: W]),
                .key_lo (keys_out[w*W +: W]),
                .key_hi (keys_out[P*W +: W])
            );
        end
    end
endmodule

// File: rtl/psort_stage.sv
module psort_stage #(
    parameter int N    = 8,
    parameter int W    = 8,
    parameter bit PIPE = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           vld_in,
    input  logic [N*W-1:0] keys_in,
    output logic           vld_out,
    output logic [N*W-1:0] keys_out
);
    if (PIPE) begin : g_reg
        typedef struct packed {
            logic           vld;
            logic [N*W-1:0] keys;
        } stage_t;

        stage_t st_d;
        stage_t st_q;

        always_comb begin
            st_d     = st_q;
            st_d.vld = rst ? 1'b0 : vld_in;
            if (vld_in) st_d.keys = keys_in;
        end

        always_ff @(posedge clk) begin
            st_q <= st_d;
        end

        assign vld_out  = st_q.vld;
        assign keys_out = st_q.keys;
    end else begin : g_wire
        assign vld_out  = vld_in;
        assign keys_out = keys_in;
    end
endmodule

// File: rtl/pairsort_net.sv
module pairsort_net #(
    parameter int N    = 8,
    parameter int W    = 8,
    parameter bit PIPE = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_vld,
    input  logic [N*W-1:0] in_keys,
    output logic           out_vld,
    output logic [N*W-1:0] out_keys
);
    localparam int LG    = $clog2(N);
    localparam int DEPTH = psort_pkg::depth_of(LG);

    logic [N*W-1:0] k_at  [DEPTH+1];
    logic           v_at  [DEPTH+1];
    logic [N*W-1:0] k_cmp [DEPTH];

    assign k_at[0] = in_keys;
    assign v_at[0] = in_vld;

    for (genvar s = 0; s < DEPTH; s++) begin : g_layer
        psort_layer #(.N(N), .W(W), .LG(LG), .SEL(s)) u_layer (
            .keys_in  (k_at[s]),
            .keys_out (k_cmp[s])
        );
        psort_stage #(.N(N), .W(W), .PIPE(PIPE)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .vld_in   (v_at[s]),
            .keys_in  (k_cmp[s]),
            .vld_out  (v_at[s+1]),
            .keys_out (k_at[s+1])
        );
    end

    assign out_vld  = v_at[DEPTH];
    assign out_keys = k_at[DEPTH];
endmodule

// File: rtl/pairsort_net_chk.sv
module pairsort_net_chk #(
    parameter int N    = 8,
    parameter int W    = 8,
    parameter bit PIPE = 1'b1
) (
    input logic           clk,
    input logic           rst,
    input logic           in_vld,
    input logic [N*W-1:0] in_keys,
    input logic           out_vld,
    input logic [N*W-1:0] out_keys
);
    localparam int LG    = $clog2(N);
    localparam int DEPTH = psort_pkg::depth_of(LG);
    localparam int SW    = W + LG;

    function automatic logic ordered(input logic [N*W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < N - 1; i++)
            if (v[i*W +: W] > v[(i+1)*W +: W]) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [SW-1:0] ksum(input logic [N*W-1:0] v);
        logic [SW-1:0] acc;
        acc = '0;
        for (int i = 0; i < N; i++) acc = acc + SW'(v[i*W +: W]);
        return acc;
    endfunction

    p_sorted_r1: assert property (@(posedge clk) disable iff (rst)
        out_vld |-> ordered(out_keys));

    if (PIPE) begin : g_seq
        logic          vld_sh [DEPTH];
        logic [SW-1:0] sum_sh [DEPTH];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) vld_sh[i] <= 1'b0;
            end else begin
                vld_sh[0] <= in_vld;
                for (int i = 1; i < DEPTH; i++) vld_sh[i] <= vld_sh[i-1];
            end
            sum_sh[0] <= ksum(in_keys);
            for (int i = 1; i < DEPTH; i++) sum_sh[i] <= sum_sh[i-1];
        end

        p_latency_r4: assert property (@(posedge clk) disable iff (rst)
            out_vld == vld_sh[DEPTH-1]);

        p_sum_kept_r2: assert property (@(posedge clk) disable iff (rst)
            out_vld |-> (ksum(out_keys) == sum_sh[DEPTH-1]));

        p_reset_drop_r6: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> !out_vld);
    end else begin : g_comb
        p_comb_vld_r5: assert property (@(posedge clk) disable iff (rst)
            out_vld == in_vld);

        p_comb_sum_r2: assert property (@(posedge clk) disable iff (rst)
            out_vld |-> (ksum(out_keys) == ksum(in_keys)));
    end
endmodule

bind pairsort_net pairsort_net_chk #(.N(N), .W(W), .PIPE(PIPE)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_keys  (in_keys),
    .out_vld  (out_vld),
    .out_keys (out_keys)
);

// File: tb/sim_pairsort_net.sv
module sim_pairsort_net;
    localparam int N   = 8;
    localparam int W   = 8;
    localparam int LAT = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_vld = 1'b0;
    logic [N*W-1:0] in_keys = '0;
    logic           o0_vld, o1_vld;
    logic [N*W-1:0] o0_keys, o1_keys;

    int n_chk = 0;
    int n_bad = 0;
    int o0_cnt = 0;

    always #5 clk = ~clk;

    pairsort_net #(.N(N), .W(W), .PIPE(1'b1)) u0 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_keys(in_keys),
        .out_vld(o0_vld), .out_keys(o0_keys)
    );

    pairsort_net #(.N(N), .W(W), .PIPE(1'b0)) u1 (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_keys(in_keys),
        .out_vld(o1_vld), .out_keys(o1_keys)
    );

    function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v);
        int a [N];
        int t;
        logic [N*W-1:0] r;
        for (int i = 0; i < N; i++) a[i] = int'(v[i*W +: W]);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N - 1 - i; j++)
                if (a[j] > a[j+1]) begin t = a[j]; a[j] = a[j+1]; a[j+1] = t; end
        for (int i = 0; i < N; i++) r[i*W +: W] = W'(a[i]);
        return r;
    endfunction

    function automatic bit is_up(input logic [N*W-1:0] v);
        for (int i = 0; i < N - 1; i++)
            if (v[i*W +: W] > v[(i+1)*W +: W]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    // Behavioural delay-queue model for the pipelined instance.
    typedef struct {
        bit             v;
        logic [N*W-1:0] k;
    } ent_t;
    ent_t mq[$];

    always @(posedge clk) begin
        if (rst) begin
            mq.delete();
            for (int i = 0; i < LAT; i++) mq.push_back('{v: 1'b0, k: '0});
        end else begin
            mq.push_back('{v: in_vld, k: ref_sort(in_keys)});
            void'(mq.pop_front());
        end
    end

    always @(negedge clk) begin
        if (!rst && mq.size() == LAT) begin
            chk(o0_vld == mq[0].v, "R4", "valid timing", {63'd0, o0_vld}, {63'd0, mq[0].v});
            if (mq[0].v) chk(o0_keys === mq[0].k, "R2", "permutation", o0_keys, mq[0].k);
            if (o0_vld) begin
                o0_cnt++;
                chk(is_up(o0_keys), "R1", "order", o0_keys, ref_sort(o0_keys));
            end
        end
    end

    task automatic put(input bit v, input logic [N*W-1:0] k, input string tag);
        @(negedge clk);
        in_vld  = v;
        in_keys = k;
        #1;
        chk(o1_vld == v, "R5", "comb valid", {63'd0, o1_vld}, {63'd0, v});
        if (v) chk(o1_keys === ref_sort(k), tag, "comb keys", o1_keys, ref_sort(k));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [N*W-1:0] k;
        logic [N*W-1:0] e;
        int c0;
        void'($urandom(17));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(o0_vld == 1'b0, "R6", "reset state", {63'd0, o0_vld}, '0);

        // R3 and R8: all zero-one groups, back to back
        c0 = o0_cnt;
        for (int p = 0; p < 256; p++) begin
            for (int i = 0; i < N; i++) k[i*W +: W] = W'(p[i]);
            put(1'b1, k, "R3");
        end
        put(1'b0, '0, "R5");
        repeat (LAT + 2) @(negedge clk);
        chk(o0_cnt - c0 == 256, "R8", "stream count", 64'(o0_cnt - c0), 64'd256);

        // random multi-bit groups with gaps
        for (int r = 0; r < 300; r++) begin
            for (int i = 0; i < N; i++) k[i*W +: W] = W'($urandom);
            put(($urandom % 4) != 0, k, "R2");
        end

        // R7: all equal
        for (int i = 0; i < N; i++) k[i*W +: W] = 8'h5A;
        put(1'b1, k, "R7");
        chk(o1_keys === k, "R7", "equal keys", o1_keys, k);
        // R9: ascending and descending
        for (int i = 0; i < N; i++) k[i*W +: W] = W'(i * 3);
        put(1'b1, k, "R9");
        chk(o1_keys === k, "R9", "ascending", o1_keys, k);
        for (int i = 0; i < N; i++) begin
            k[i*W +: W] = W'(N - 1 - i);
            e[i*W +: W] = W'(i);
        end
        put(1'b1, k, "R9");
        chk(o1_keys === e, "R9", "descending", o1_keys, e);
        // extremes
        for (int i = 0; i < N; i++) k[i*W +: W] = (i % 2 == 0) ? 8'hFF : 8'h00;
        put(1'b1, k, "R1");
        put(1'b0, '0, "R5");
        repeat (LAT + 2) @(negedge clk);

        // R6: reset with groups in flight
        put(1'b1, {N{8'h11}}, "R6");
        put(1'b1, {N{8'h22}}, "R6");
        put(1'b0, '0, "R5");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        c0 = o0_cnt;
        repeat (LAT + 3) @(negedge clk);
        chk(o0_cnt == c0, "R6", "dropped groups", 64'(o0_cnt - c0), 64'd0);
        put(1'b1, {N{8'h33}}, "R6");
        put(1'b0, '0, "R5");
        repeat (LAT + 2) @(negedge clk);
        chk(o0_cnt == c0 + 1, "R6", "post-reset group", 64'(o0_cnt - c0), 64'd1);

        $display("  [TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule